// File: doc/BRIEF.md
# Translation Cache Lookup Controller

This block translates addresses for one access path. Each request carries a logical address, a privilege level, a write flag and a transparent-range hit flag from outside. The block answers in the same cycle in one of four ways. It can return a physical address. It can signal a bus error or an access error. Or it can stall the requester while it asks an external page-table walker for the mapping.

Translations are held in a small, fully associative cache. Each entry is tagged by privilege and virtual page number and carries four bits: resident, write-protect and modified, plus a valid flag. The lookup runs in a fixed order. A transparent hit passes the address through unchanged. Otherwise a cache hit is used. If neither hits, a walk is started.

A walk is also started for the first write to a clean page, so that the modified bit gets set. A walk that completed with an error leaves a non-resident entry, and any later hit on that entry fails with a bus error. After a walk finishes, the requester holds its request and the access is retried against the updated cache.

Top module: `xlat_lookup_ctrl`

## Requirements
- R1: When `tt_hit_i` is high with a request and no walk is pending, `resp_valid_o` is high in the same cycle with `resp_paddr_o` equal to `req_vaddr_i`. No fault is raised, whatever the cache holds.
- R2: The cache hits only when both the privilege bit and the virtual page number (address bits 31:12) match. A page cached at one privilege level misses at the other.
- R3: A request that hits nothing raises `stall_o` in the same cycle. From the next cycle `walk_req_o` is high, with `walk_vpn_o` and `walk_super_o` taken from the request and `walk_set_mod_o` low.
- R4: The cycle after `walk_ack_i`, `walk_req_o` is low and the entry is installed. The retried request then returns `{walk_ppn_i, req_vaddr_i[11:0]}` with `stall_o` low.
- R5: A hit on an entry installed with `walk_err_i` high raises `bus_err_o`, with no stall and no walk.
- R6: A write that hits a write-protected resident entry raises `acc_err_o` and no translation. A read of the same page translates.
- R7: A write that hits a resident, unprotected, unmodified entry stalls and walks with `walk_set_mod_o` high. After the acknowledge, that write and later writes translate without a walk.
- R8: A read hit on a resident entry translates without a walk, even when the modified bit is clear.
- R9: New entries fill slots in round-robin order. After the cache is flushed, the 17th install evicts the first page installed, and the second page still hits.
- R10: A one-cycle pulse on `flush_i` invalidates every entry, so the next access to a cached page stalls.
- R11: When `flush_i` coincides with `walk_ack_i`, the entry being installed stays valid and every other entry is invalidated.
- R12: During and after reset all outputs are low and the cache is empty, so the first access misses.
- R13: While `walk_req_o` is high without an acknowledge, it stays high and `walk_vpn_o` stays stable. Only one walk is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_vaddr_i | input | 32 | Logical address |
| req_super_i | input | 1 | Privileged access |
| req_write_i | input | 1 | Write or read-modify-write |
| tt_hit_i | input | 1 | Transparent range matched |
| flush_i | input | 1 | Invalidate all cache entries |
| resp_valid_o | output | 1 | Translation valid this cycle |
| resp_paddr_o | output | 32 | Physical address |
| stall_o | output | 1 | Requester must hold and retry |
| bus_err_o | output | 1 | Hit on a non-resident entry |
| acc_err_o | output | 1 | Write to a protected page |
| walk_req_o | output | 1 | Table walk request |
| walk_vpn_o | output | 20 | Page to walk |
| walk_super_o | output | 1 | Privilege of the walked page |
| walk_set_mod_o | output | 1 | Walk is for setting the modified bit |
| walk_ack_i | input | 1 | Walk complete, response valid |
| walk_ppn_i | input | 20 | Physical page number from the walk |
| walk_wp_i | input | 1 | Page is write-protected |
| walk_mod_i | input | 1 | Page modified bit |
| walk_err_i | input | 1 | Walk failed or descriptor invalid |

## Verification
The flush and the install triggered by a walk acknowledge can fall on the same clock edge. The bench provokes this by driving `flush_i` high in exactly the cycle that `walk_ack_i` is high. It then judges the result at the ports. The held request must retry as a hit with the new physical page and no new walk. A page that was cached before that edge must then miss and stall.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int PAGE_W = 12;
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int PPN_W  = PA_W - PAGE_W;

  typedef struct packed {
    logic             valid;
    logic             priv;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             resident;
    logic             wprot;
    logic             dirty;
  } xlat_entry_t;

  typedef enum logic [0:0] {ST_LOOKUP, ST_WALK} ctrl_state_e;
endpackage

// File: rtl/xlat_rr_ptr.sv
`timescale 1ns/1ps
module xlat_rr_ptr #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/xlat_tag_array.sv
`timescale 1ns/1ps
module xlat_tag_array import xlat_pkg::*; #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             lk_priv_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [IDX_W-1:0] lk_idx_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  output logic             lk_res_o,
  output logic             lk_wp_o,
  output logic             lk_dirty_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  xlat_entry_t      wr_entry_i
);
  xlat_entry_t        ent_w [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] valid_w;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xlat_entry_t e_q;
    // install wins over flush for its own slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    e_q       <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))      e_q       <= wr_entry_i;
      else if (flush_i)                               e_q.valid <= 1'b0;
    end
    assign ent_w[g]   = e_q;
    assign valid_w[g] = e_q.valid;
    assign match[g]   = e_q.valid && (e_q.priv == lk_priv_i) && (e_q.vpn == lk_vpn_i);
  end

  always_comb begin
    lk_idx_o   = '0;
    lk_ppn_o   = '0;
    lk_res_o   = 1'b0;
    lk_wp_o    = 1'b0;
    lk_dirty_o = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_idx_o   = IDX_W'(i);
        lk_ppn_o   = ent_w[i].ppn;
        lk_res_o   = ent_w[i].resident;
        lk_wp_o    = ent_w[i].wprot;
        lk_dirty_o = ent_w[i].dirty;
      end
    end
  end

  assign lk_hit_o = |match;

  AST_TAG_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)); // R9
  AST_FLUSH_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !wr_en_i |=> valid_w == '0); // R10
  AST_FLUSH_KEEP_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && wr_en_i |=> $countones(valid_w) == 1); // R11
endmodule

// File: rtl/xlat_lookup_ctrl.sv
`timescale 1ns/1ps
module xlat_lookup_ctrl import xlat_pkg::*; #(
  parameter int ENTRIES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_super_i,
  input  logic             req_write_i,
  input  logic             tt_hit_i,
  input  logic             flush_i,
  output logic             resp_valid_o,
  output logic [PA_W-1:0]  resp_paddr_o,
  output logic             stall_o,
  output logic             bus_err_o,
  output logic             acc_err_o,
  output logic             walk_req_o,
  output logic [VPN_W-1:0] walk_vpn_o,
  output logic             walk_super_o,
  output logic             walk_set_mod_o,
  input  logic             walk_ack_i,
  input  logic [PPN_W-1:0] walk_ppn_i,
  input  logic             walk_wp_i,
  input  logic             walk_mod_i,
  input  logic             walk_err_i
);
  localparam int IDX_W = $clog2(ENTRIES);

  ctrl_state_e      state_q;
  logic [VPN_W-1:0] pend_vpn_q;
  logic             pend_priv_q, pend_setmod_q;
  logic [IDX_W-1:0] pend_idx_q;

  logic [VPN_W-1:0] lk_vpn;
  logic             hit, hit_res, hit_wp, hit_dirty;
  logic [IDX_W-1:0] hit_idx, rr_idx;
  logic [PPN_W-1:0] hit_ppn;
  logic             idle_req, use_tt, use_cache, miss, bad_page, prot, clean, xlat_ok, start_walk;
  logic             install;
  xlat_entry_t      new_entry;

  assign lk_vpn = req_vaddr_i[VA_W-1:PAGE_W];

  xlat_tag_array #(.ENTRIES(ENTRIES)) u_tags (
    .clk_i, .rst_ni, .flush_i,
    .lk_priv_i(req_super_i), .lk_vpn_i(lk_vpn),
    .lk_hit_o(hit), .lk_idx_o(hit_idx), .lk_ppn_o(hit_ppn),
    .lk_res_o(hit_res), .lk_wp_o(hit_wp), .lk_dirty_o(hit_dirty),
    .wr_en_i(install), .wr_idx_i(pend_idx_q), .wr_entry_i(new_entry)
  );

  xlat_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
    .clk_i, .rst_ni, .adv_i(install && !pend_setmod_q), .ptr_o(rr_idx)
  );

  // fixed order: transparent, then cache, then walk
  assign idle_req   = (state_q == ST_LOOKUP) && req_valid_i;
  assign use_tt     = idle_req && tt_hit_i;
  assign use_cache  = idle_req && !tt_hit_i && hit;
  assign miss       = idle_req && !tt_hit_i && !hit;
  assign bad_page   = use_cache && !hit_res;
  assign prot       = use_cache && hit_res && req_write_i && hit_wp;
  assign clean      = use_cache && hit_res && req_write_i && !hit_wp && !hit_dirty;
  assign xlat_ok    = use_cache && hit_res && !(req_write_i && (hit_wp || !hit_dirty));
  assign start_walk = miss || clean;

  assign install = (state_q == ST_WALK) && walk_ack_i;

  always_comb begin
    new_entry          = '0;
    new_entry.valid    = 1'b1;
    new_entry.priv     = pend_priv_q;
    new_entry.vpn      = pend_vpn_q;
    new_entry.ppn      = walk_ppn_i;
    new_entry.resident = !walk_err_i;
    new_entry.wprot    = walk_wp_i;
    new_entry.dirty    = walk_mod_i || pend_setmod_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_LOOKUP;
      pend_vpn_q    <= '0;
      pend_priv_q   <= 1'b0;
      pend_setmod_q <= 1'b0;
      pend_idx_q    <= '0;
    end else begin
      case (state_q)
        ST_LOOKUP: if (start_walk) begin
          state_q       <= ST_WALK;
          pend_vpn_q    <= lk_vpn;
          pend_priv_q   <= req_super_i;
          pend_setmod_q <= clean;
          pend_idx_q    <= clean ? hit_idx : rr_idx;
        end
        ST_WALK: if (walk_ack_i) state_q <= ST_LOOKUP;
        default: state_q <= ST_LOOKUP;
      endcase
    end
  end

  assign resp_valid_o   = use_tt || xlat_ok;
  assign resp_paddr_o   = use_tt ? PA_W'(req_vaddr_i) : {hit_ppn, req_vaddr_i[PAGE_W-1:0]};
  assign stall_o        = start_walk || (state_q == ST_WALK);
  assign bus_err_o      = bad_page;
  assign acc_err_o      = prot;
  assign walk_req_o     = (state_q == ST_WALK);
  assign walk_vpn_o     = pend_vpn_q;
  assign walk_super_o   = pend_priv_q;
  assign walk_set_mod_o = pend_setmod_q;

  AST_TT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && tt_hit_i && !walk_req_o |-> resp_valid_o && !bus_err_o && !acc_err_o); // R1
  AST_MISS_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && !walk_req_o |=> walk_req_o); // R3
  AST_ACK_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o && walk_ack_i |=> !walk_req_o); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({resp_valid_o, stall_o, bus_err_o, acc_err_o})); // R6
  AST_WALK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o && !walk_ack_i |=> walk_req_o && $stable(walk_vpn_o) && $stable(walk_set_mod_o)); // R13
endmodule

// File: tb/sim_xlat_lookup_ctrl.sv
`timescale 1ns/1ps
module sim_xlat_lookup_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_super = 1'b0, req_write = 1'b0, tt_hit = 1'b0, flush = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        resp_valid, stall, bus_err, acc_err, walk_req, walk_super, walk_set_mod;
  logic [31:0] resp_paddr;
  logic [19:0] walk_vpn;
  logic        walk_ack = 1'b0, walk_wp = 1'b0, walk_mod = 1'b0, walk_err = 1'b0;
  logic [19:0] walk_ppn = '0;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  xlat_lookup_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_super_i(req_super), .req_write_i(req_write), .tt_hit_i(tt_hit), .flush_i(flush),
    .resp_valid_o(resp_valid), .resp_paddr_o(resp_paddr), .stall_o(stall),
    .bus_err_o(bus_err), .acc_err_o(acc_err), .walk_req_o(walk_req), .walk_vpn_o(walk_vpn),
    .walk_super_o(walk_super), .walk_set_mod_o(walk_set_mod), .walk_ack_i(walk_ack),
    .walk_ppn_i(walk_ppn), .walk_wp_i(walk_wp), .walk_mod_i(walk_mod), .walk_err_i(walk_err)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        sup;
    logic        wr;
    logic [31:0] exp_pa;
  } tt_vec_t;

  localparam tt_vec_t TT_VEC [4] = '{
    '{32'h0000_1000, 1'b0, 1'b0, 32'h0000_1000},
    '{32'hFFFF_FFFC, 1'b1, 1'b1, 32'hFFFF_FFFC},
    '{32'h1234_5678, 1'b0, 1'b1, 32'h1234_5678},
    '{32'h8000_0ABC, 1'b1, 1'b0, 32'h8000_0ABC}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] va, input logic sup, input logic wr, input logic tt);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_super = sup; req_write = wr; tt_hit = tt;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; tt_hit = 1'b0; req_write = 1'b0;
    #1;
  endtask

  task automatic walk_finish(input logic [19:0] ppn, input logic wp, input logic md, input logic er,
                             input logic [19:0] exp_vpn, input logic exp_sup, input logic exp_sm,
                             input string tag, input bit hold, input bit fl);
    @(negedge clk); #1;
    chk({tag, " walk_req"}, walk_req, 1);
    chk({tag, " walk_vpn"}, walk_vpn, exp_vpn);
    chk({tag, " walk_super"}, walk_super, exp_sup);
    chk({tag, " walk_set_mod"}, walk_set_mod, exp_sm);
    if (hold) begin
      @(negedge clk); #1;
      chk("R13 walk_req held", walk_req, 1);
      chk("R13 walk_vpn stable", walk_vpn, exp_vpn);
    end
    walk_ack = 1'b1; walk_ppn = ppn; walk_wp = wp; walk_mod = md; walk_err = er; flush = fl;
    @(negedge clk);
    walk_ack = 1'b0; flush = 1'b0;
    #1;
    chk("R4 walk_req dropped", walk_req, 0);
  endtask

  task automatic miss_walk(input logic [31:0] va, input logic sup, input logic wr,
                           input logic [19:0] ppn, input logic wp, input logic md, input logic er,
                           input logic exp_sm, input string tag, input bit hold, input bit fl);
    drive(va, sup, wr, 1'b0);
    chk({tag, " stall on lookup"}, stall, 1);
    walk_finish(ppn, wp, md, er, va[31:12], sup, exp_sm, tag, hold, fl);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R12 outputs in reset", {resp_valid, stall, bus_err, acc_err, walk_req}, 5'b0);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk("R12 outputs after reset", {resp_valid, stall, bus_err, acc_err, walk_req}, 5'b0);

    // R1: transparent passthrough vectors
    for (int k = 0; k < 4; k++) begin
      drive(TT_VEC[k].va, TT_VEC[k].sup, TT_VEC[k].wr, 1'b1);
      chk("R1 tt resp_valid", resp_valid, 1);
      chk("R1 tt paddr", resp_paddr, TT_VEC[k].exp_pa);
      chk("R1 tt no stall", stall, 0);
    end
    idle();

    // R3/R12/R4: first access misses, walk held, retry hits
    miss_walk(32'h0001_2345, 0, 0, 20'hABCDE, 0, 0, 0, 0, "R3", 1, 0);
    chk("R4 retry valid", resp_valid, 1);
    chk("R4 retry paddr", resp_paddr, 32'hABCD_E345);
    chk("R4 retry no stall", stall, 0);
    idle();
    // R8: read of clean page
    drive(32'h0001_2FF0, 0, 0, 0);
    chk("R8 clean read valid", resp_valid, 1);
    chk("R8 clean read paddr", resp_paddr, 32'hABCD_EFF0);
    @(negedge clk); #1;
    chk("R8 no walk", walk_req, 0);
    idle();

    // R2: same page other privilege misses
    miss_walk(32'h0001_2345, 1, 0, 20'h11111, 0, 1, 0, 0, "R2", 0, 0);
    chk("R2 super paddr", resp_paddr, 32'h1111_1345);
    idle();

    // R7: write to clean page
    miss_walk(32'h0001_2ABC, 0, 1, 20'hABCDE, 0, 1, 0, 1, "R7", 0, 0);
    chk("R7 retry valid", resp_valid, 1);
    chk("R7 retry paddr", resp_paddr, 32'hABCD_EABC);
    idle();
    drive(32'h0001_2010, 0, 1, 0);
    chk("R7 second write valid", resp_valid, 1);
    chk("R7 second write no stall", stall, 0);
    idle();

    // R6: protected page
    miss_walk(32'h0003_4010, 0, 1, 20'h33333, 1, 0, 0, 0, "R6", 0, 0);
    chk("R6 acc_err", acc_err, 1);
    chk("R6 no resp", resp_valid, 0);
    idle();
    drive(32'h0003_4010, 0, 0, 0);
    chk("R6 read ok", resp_valid, 1);
    chk("R6 read paddr", resp_paddr, 32'h3333_3010);
    idle();

    // R5: failed walk entry
    miss_walk(32'h0005_6000, 0, 0, 20'h44444, 0, 0, 1, 0, "R5", 0, 0);
    chk("R5 bus_err", bus_err, 1);
    chk("R5 no resp", resp_valid, 0);
    chk("R5 no stall", stall, 0);
    @(negedge clk); #1;
    chk("R5 no walk", walk_req, 0);
    drive(32'h0005_6000, 0, 0, 1);
    chk("R1 tt over bad entry", {resp_valid, bus_err}, 2'b10);
    chk("R1 tt over bad paddr", resp_paddr, 32'h0005_6000);
    idle();

    // R11: flush coinciding with install
    miss_walk(32'h0007_8ABC, 0, 0, 20'h55555, 0, 1, 0, 0, "R11", 0, 1);
    chk("R11 new entry hit", resp_valid, 1);
    chk("R11 new entry paddr", resp_paddr, 32'h5555_5ABC);
    idle();
    drive(32'h0003_4010, 0, 0, 0);
    chk("R11 old entry gone", stall, 1);
    walk_finish(20'h33333, 1, 0, 0, 20'h00034, 0, 0, "R11", 0, 0);
    idle();

    // R10: plain flush
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    drive(32'h0007_8ABC, 0, 0, 0);
    chk("R10 miss after flush", stall, 1);
    walk_finish(20'h55555, 0, 1, 0, 20'h00078, 0, 0, "R10", 0, 0);
    idle();

    // R9: round-robin after flush
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 16; i++) begin
      miss_walk(32'(20'h00100 + i) << 12, 0, 0, 20'h80000 + 20'(i), 0, 1, 0, 0, "R9", 0, 0);
      idle();
    end
    drive(32'h0010_0004, 0, 0, 0);
    chk("R9 first page hits", resp_valid, 1);
    chk("R9 first page paddr", resp_paddr, 32'h8000_0004);
    drive(32'h0010_F008, 0, 0, 0);
    chk("R9 last page hits", resp_paddr, 32'h8000_F008);
    miss_walk(32'h0011_0000, 0, 0, 20'h90000, 0, 1, 0, 0, "R9", 0, 0);
    idle();
    drive(32'h0010_1000, 0, 0, 0);
    chk("R9 second page kept", {resp_valid, stall}, 2'b10);
    drive(32'h0010_0000, 0, 0, 0);
    chk("R9 first page evicted", stall, 1);
    walk_finish(20'h80000, 0, 1, 0, 20'h00100, 0, 0, "R9", 0, 0);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule